// File: doc/BRIEF.md
# Chained conditional-skip sequencer

This block steps the program counter past instructions when a conditional test has failed. A pulse on `start` loads the address of the first instruction to pass over. The sequencer then fetches that word through a synchronous read port and works out how many words the instruction takes up from its opcode and operand fields. It moves the counter past the whole instruction. If the word it just passed is itself a conditional test, it fetches and passes the next one as well. The chain therefore ends only once a non-conditional instruction has been passed over.

When the chain ends, the sequencer raises `done` for one cycle. It presents the resulting program counter and the number of instructions it skipped. `busy` is high for the whole walk, so the surrounding core can hold off interrupt service during that time. Executing instructions and evaluating conditions are done elsewhere.

Top module: `skip_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_rd` are 0, and `final_pc` and `skip_cycles` are 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle. In that same cycle the block issues a read (`mem_rd`=1) at `mem_addr` equal to the captured `start_pc`.
- R3: The instruction word fields are: opcode in bits 4:0, b operand code in bits 9:5, and a operand code in bits 15:10. An operand code of 0x10 to 0x17, 0x1A, 0x1E or 0x1F needs one extra word. A word with a nonzero opcode occupies 1 word, plus 1 if its a code needs an extra word, plus 1 if its b code needs one.
- R4: A word with opcode 0 occupies 1 word, plus 1 if its a code needs an extra word. Its b field never adds length.
- R5: A word with opcode 0x10 to 0x17 inclusive is conditional, and the instruction after it is also skipped. Opcodes 0x0F and 0x18 are not conditional.
- R6: The walk ends right after the first non-conditional instruction is passed. `done` is then high for exactly one cycle, and `busy` is 0 in that cycle.
- R7: `skip_cycles` equals the number of instructions skipped in the walk and is cleared at each start. For N skipped instructions, `done` appears 2N+1 cycles after the cycle in which `start` was sampled.
- R8: Program counter arithmetic wraps modulo 2^16.
- R9: A `start` pulse while `busy` is 1 is ignored. The walk in progress finishes with its own result.
- R10: `mem_rd` is high only while `busy`, for one cycle per skipped instruction. The read data is expected on the cycle after `mem_rd`.
- R11: `skip_cycles` saturates at its maximum value (255 by default) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a skip walk (taken only while idle) |
| start_pc | input | 16 | Address of the first instruction to skip |
| mem_rd | output | 1 | Read request to instruction memory |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| busy | output | 1 | Walk in progress; hold off interrupts |
| done | output | 1 | One-cycle pulse at the end of a walk |
| final_pc | output | 16 | Program counter after the last skipped instruction |
| skip_cycles | output | 8 | Number of instructions skipped |

## Verification
If the decoded length is wrong, `final_pc` is off at the very next `done`. If the conditional range is wrong, the chain is cut short or runs on. That shows up at once as a wrong `skip_cycles`, a wrong count of `mem_rd` pulses, and a shifted `done` time. A stuck or badly sequenced state machine shows up as `done` arriving at a cycle other than 2N+1, or as `busy` and `done` overlapping. A counter fault shows only in walks long enough to reach saturation, so one chain of more than 255 conditionals is run.

// File: rtl/skip_seq_pkg.sv
package skip_seq_pkg;
   localparam int WORD_W = 16;
   localparam int OPC_W  = 5;
   localparam int BFLD_W = 5;
   localparam int AFLD_W = 6;

   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT} seq_state_t;

   // operand codes that pull one extra word from the instruction stream
   function automatic logic opnd_extra(input logic [AFLD_W-1:0] code);
      return ((code >= 6'h10) && (code <= 6'h17)) ||
             (code == 6'h1A) || (code == 6'h1E) || (code == 6'h1F);
   endfunction
endpackage

// File: rtl/skip_len_dec.sv
module skip_len_dec
   import skip_seq_pkg::*;
#(
   parameter logic [OPC_W-1:0] COND_LO = 5'h10,
   parameter logic [OPC_W-1:0] COND_HI = 5'h17
) (
   input  logic [WORD_W-1:0] word,
   output logic [1:0]        len,
   output logic              is_cond
);
   if (COND_LO > COND_HI) begin : g_bad_range
      $error("skip_len_dec: COND_LO above COND_HI");
   end

   logic [OPC_W-1:0]  opc;
   logic [BFLD_W-1:0] bcode;
   logic [AFLD_W-1:0] acode;
   logic              a_ext, b_ext, special;

   always_comb begin
      opc     = word[OPC_W-1:0];
      bcode   = word[OPC_W+BFLD_W-1:OPC_W];
      acode   = word[WORD_W-1:OPC_W+BFLD_W];
      special = (opc == '0);
      a_ext   = opnd_extra(acode);
      b_ext   = !special && opnd_extra({1'b0, bcode});
      len     = 2'd1 + {1'b0, a_ext} + {1'b0, b_ext};
      is_cond = (opc >= COND_LO) && (opc <= COND_HI);
   end
endmodule

// File: rtl/skip_cnt.sv
module skip_cnt #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_w
      $error("skip_cnt: CNT_W must be at least 2");
   end

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                    cnt <= '0;
         else if (clr)                  cnt <= '0;
         else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end

      // R11
      sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (inc && !clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
      // R7
      cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (inc && !clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)   cnt <= '0;
         else if (clr) cnt <= '0;
         else if (inc) cnt <= cnt + 1'b1;
      end

      // R7
      cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (inc && !clr) |=> (cnt == $past(cnt) + 1'b1));
   end

   // R7
   cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/skip_ctrl.sv
module skip_ctrl
   import skip_seq_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [PC_W-1:0] start_pc,
   input  logic [1:0]      len,
   input  logic            is_cond,
   output logic            mem_rd,
   output logic [PC_W-1:0] pc,
   output logic            busy,
   output logic            done,
   output logic            step,
   output logic            clr
);
   if (PC_W < 2 || PC_W > 32) begin : g_bad_pc
      $error("skip_ctrl: PC_W out of range");
   end

   seq_state_t st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         pc   <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               pc <= start_pc;
               st <= ST_FETCH;
            end
            ST_FETCH: st <= ST_WAIT;
            ST_WAIT: begin
               pc <= pc + PC_W'(len);
               if (is_cond) st <= ST_FETCH;
               else begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_rd = (st == ST_FETCH);
      busy   = (st != ST_IDLE);
      step   = (st == ST_WAIT);
      clr    = start && (st == ST_IDLE);
   end

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy);
   // R10
   rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);
   // R2
   start_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mem_rd && pc == $past(start_pc)));
   // R9
   fetch_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> $stable(pc));
endmodule

// File: rtl/skip_seq.sv
module skip_seq
   import skip_seq_pkg::*;
#(
   parameter int PC_W     = 16,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PC_W-1:0]   start_pc,
   output logic              mem_rd,
   output logic [PC_W-1:0]   mem_addr,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [PC_W-1:0]   final_pc,
   output logic [CNT_W-1:0]  skip_cycles
);
   logic [1:0]      len;
   logic            is_cond;
   logic            step, clr;
   logic [PC_W-1:0] pc;

   skip_len_dec u_dec (
      .word    (mem_rdata),
      .len     (len),
      .is_cond (is_cond)
   );

   skip_ctrl #(.PC_W(PC_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .start_pc (start_pc),
      .len      (len),
      .is_cond  (is_cond),
      .mem_rd   (mem_rd),
      .pc       (pc),
      .busy     (busy),
      .done     (done),
      .step     (step),
      .clr      (clr)
   );

   skip_cnt #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (step),
      .cnt   (skip_cycles)
   );

   assign mem_addr = pc;
   assign final_pc = pc;
endmodule

// File: tb/skip_seq_tb.sv
module skip_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] start_pc = '0;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic        busy, done;
   logic [15:0] final_pc;
   logic [7:0]  skip_cycles;

   int errs = 0;
   int nchk = 0;
   logic [15:0] bmem [256];

   always #2.5 clk = ~clk;

   skip_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .final_pc(final_pc), .skip_cycles(skip_cycles)
   );

   function automatic logic [15:0] w(int op, int b, int a);
      return {a[5:0], b[4:0], op[4:0]};
   endfunction

   // region 0x1000-0x11FF: one-word conditionals, 0x1200 onward: one-word plain
   function automatic logic [15:0] fetch(logic [15:0] ad);
      if (ad[15:12] == 4'h1) return (ad < 16'h1200) ? w(16'h10, 0, 0) : w(1, 0, 0);
      return bmem[ad[7:0]];
   endfunction

   always_ff @(posedge clk) if (mem_rd) mem_rdata <= fetch(mem_addr);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_skip(input logic [15:0] spc, input bit poke,
                           output logic [15:0] rpc, output int rcnt,
                           output int lat, output int nrd, output bit pulse_ok);
      @(negedge clk); start = 1'b1; start_pc = spc;
      @(negedge clk); start = 1'b0;
      lat = 1; nrd = 0;
      while (!done && lat < 3000) begin
         if (mem_rd) nrd++;
         if (poke && lat == 3) begin start = 1'b1; start_pc = 16'h0000; end
         else start = 1'b0;
         @(negedge clk); lat++;
      end
      start = 1'b0;
      rpc = final_pc; rcnt = int'(skip_cycles);
      pulse_ok = done && !busy;
      @(negedge clk);
      pulse_ok = pulse_ok && !done;
   endtask

   // start, expected pc, expected count, requirement
   localparam logic [15:0] VEC [0:8][0:3] = '{
      '{16'h0000, 16'h0001, 16'd1,  16'd3},  // R3 one word
      '{16'h0004, 16'h0007, 16'd1,  16'd3},  // R3 both operands extend
      '{16'h0008, 16'h000A, 16'd1,  16'd3},  // R3 b only
      '{16'h000C, 16'h000E, 16'd1,  16'd4},  // R4 special, a extends
      '{16'h0010, 16'h0011, 16'd1,  16'd4},  // R4 special, b ignored
      '{16'h0020, 16'h0029, 16'd5,  16'd5},  // R5 chain of four conditionals
      '{16'h0030, 16'h0031, 16'd1,  16'd5},  // R5 opcode 0x0F plain
      '{16'h0032, 16'h0033, 16'd1,  16'd5},  // R5 opcode 0x18 plain
      '{16'hFFFF, 16'h0002, 16'd1,  16'd8}   // R8 wrap
   };

   initial begin
      repeat (150000) @(posedge clk);
      errs++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
   end

   initial begin
      logic [15:0] rpc;
      int rcnt, lat, nrd;
      bit pok;
      for (int i = 0; i < 256; i++) bmem[i] = 16'h0000;
      bmem[8'h00] = w(1, 0, 0);
      bmem[8'h04] = w(1, 16'h1E, 16'h1F);
      bmem[8'h08] = w(2, 16'h10, 16'h21);
      bmem[8'h0C] = w(0, 1, 16'h1A);
      bmem[8'h10] = w(0, 16'h1E, 0);
      bmem[8'h20] = w(16'h12, 0, 16'h1F);
      bmem[8'h22] = w(16'h13, 16'h1E, 16'h1F);
      bmem[8'h25] = w(16'h10, 0, 16'h20);
      bmem[8'h26] = w(16'h17, 0, 0);
      bmem[8'h27] = w(1, 0, 16'h1F);
      bmem[8'h30] = w(16'h0F, 0, 0);
      bmem[8'h32] = w(16'h18, 0, 0);
      bmem[8'hFF] = w(1, 16'h1F, 16'h1E);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 mem_rd", mem_rd, 0);
      check("R1 final_pc", final_pc, 0);
      check("R1 skip_cycles", skip_cycles, 0);

      for (int i = 0; i < 9; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i][3], i);
         run_skip(VEC[i][0], 1'b0, rpc, rcnt, lat, nrd, pok);
         check({tag, " pc"}, rpc, VEC[i][1]);
         check({tag, " count R7"}, rcnt, VEC[i][2]);
         check({tag, " latency R7"}, lat, 2 * VEC[i][2] + 1);
         check({tag, " reads R10"}, nrd, VEC[i][2]);
         check({tag, " done pulse R6"}, pok, 1);
      end

      // R2: first cycle after start
      @(negedge clk); start = 1'b1; start_pc = 16'h0004;
      @(negedge clk); start = 1'b0;
      check("R2 busy", busy, 1);
      check("R2 mem_rd", mem_rd, 1);
      check("R2 mem_addr", mem_addr, 16'h0004);
      repeat (4) @(negedge clk);
      check("R10 idle no read", mem_rd, 0);

      // R11: 513 skips saturate the counter
      run_skip(16'h1000, 1'b0, rpc, rcnt, lat, nrd, pok);
      check("R11 pc", rpc, 16'h1201);
      check("R11 count", rcnt, 255);
      check("R11 latency", lat, 1027);

      // R9: start during the walk is ignored
      run_skip(16'h1000, 1'b1, rpc, rcnt, lat, nrd, pok);
      check("R9 pc", rpc, 16'h1201);
      check("R9 latency", lat, 1027);
      check("R9 reads", nrd, 513);
      repeat (2) @(negedge clk);
      check("R9 idle after", busy, 0);

      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
   end
endmodule